// File: doc/BRIEF.md
# Width-Converting FIFO Controller

A single-clock first-in first-out buffer whose write port and read port carry words of different widths. The wider of the two widths is a whole multiple of the narrower one. Internally the storage is kept as a ring of narrow units, so one write stores one or more units and one read takes one or more units. Narrow writes are packed into a wide read word, and a wide write is unpacked into several narrow reads. In both directions the least significant part is handled first.

Occupancy is counted in narrow units. Each side judges its own flag in whole words of its own width. The full flag means a complete write word would not fit. The empty flag means no complete read word is present. A partial word can therefore sit inside the buffer while the reader still sees it as empty.

Writes that arrive while full are dropped, and reads that arrive while empty are dropped. Each dropped request produces a one-cycle error pulse on the following clock. Read data is registered, and a valid strobe marks the cycle in which new data appears.

Top module: `wc_fifo`

## Requirements
- R1: After reset, empty is 1, full is 0, and rdValid, overflow and underflow are 0.
- R2: When writes are narrower than reads, the first accepted write lands in the least significant bits of the read word. With 4-bit writes 0xA then 0x5, an 8-bit read returns 0x5A.
- R3: When writes are wider than reads, the least significant part is read out first. A 16-bit write of 0xABCD, read at 8 bits, gives 0xCD and then 0xAB.
- R4: full is 1 exactly when fewer free narrow units remain than one write word needs. It stays 1 while a read has freed only part of a write word.
- R5: empty is 1 exactly when fewer stored narrow units remain than one read word needs. A lone partial write leaves empty at 1.
- R6: A write while full stores nothing and changes nothing. overflow is 1 on the clock after each such write, for one cycle per dropped write.
- R7: A read while empty returns nothing and changes nothing. underflow is 1 on the clock after each such read, and rdValid stays 0.
- R8: The data of an accepted read appears on rdData one clock later, with rdValid high for that one cycle. rdData holds its value until the next accepted read.
- R9: A write and a read in the same cycle are both accepted when each is legal. Data leaves in write order across wraps of the storage ring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write request |
| wrData | input | WR_W | Write word |
| rdEn | input | 1 | Read request |
| rdData | output | RD_W | Registered read word |
| rdValid | output | 1 | One-cycle strobe for new rdData |
| full | output | 1 | No room for a complete write word |
| empty | output | 1 | No complete read word stored |
| overflow | output | 1 | Pulse after a dropped write |
| underflow | output | 1 | Pulse after a dropped read |

## Verification
The packing direction is tried with two nibbles of different values. A swapped or mis-shifted sub-word order shows up as 0xA5 instead of 0x5A. The unpacking direction uses 0xABCD on a second instance with a 16-bit write and 8-bit read, so both halves and their order are visible. A fill with counting nibbles and a drain across the ring boundary, together with a stream of writes interleaved with reads on alternate cycles, separate correct pointer wrap and same-cycle accept from off-by-one pointer and count updates. The half-freed state in the wide-write instance separates a full flag judged in write words from one judged in single units.

// File: rtl/wc_fifo_pkg.sv
package wc_fifo_pkg;
  // Accept strobes passed from control to datapath
  typedef struct packed {
    logic wrAccept;
    logic rdAccept;
  } fifoStrobe_t;
endpackage

// File: rtl/wc_fifo_ctrl.sv
module wc_fifo_ctrl
  import wc_fifo_pkg::*;
#(
  parameter int UNITS    = 16,
  parameter int WR_RATIO = 1,
  parameter int RD_RATIO = 2,
  parameter int PTR_W    = $clog2(UNITS),
  parameter int CNT_W    = $clog2(UNITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  output fifoStrobe_t      strb,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             full,
  output logic             empty,
  output logic             overflow,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] FULL_LIMIT  = CNT_W'(UNITS - WR_RATIO);
  localparam logic [CNT_W-1:0] EMPTY_LIMIT = CNT_W'(RD_RATIO);

  logic [CNT_W-1:0] unitCount;
  logic [CNT_W-1:0] countNext;
  logic [PTR_W:0]   wrSum;
  logic [PTR_W:0]   rdSum;
  logic [PTR_W-1:0] wrPtrNext;
  logic [PTR_W-1:0] rdPtrNext;

  // Flags judged in whole words of each side
  assign full  = unitCount > FULL_LIMIT;
  assign empty = unitCount < EMPTY_LIMIT;

  assign strb.wrAccept = wrEn && !full;
  assign strb.rdAccept = rdEn && !empty;

  always_comb begin
    wrSum = {1'b0, wrPtr} + (PTR_W+1)'(WR_RATIO);
    rdSum = {1'b0, rdPtr} + (PTR_W+1)'(RD_RATIO);
    wrPtrNext = (wrSum >= (PTR_W+1)'(UNITS)) ? PTR_W'(wrSum - (PTR_W+1)'(UNITS)) : PTR_W'(wrSum);
    rdPtrNext = (rdSum >= (PTR_W+1)'(UNITS)) ? PTR_W'(rdSum - (PTR_W+1)'(UNITS)) : PTR_W'(rdSum);
    countNext = unitCount;
    if (strb.wrAccept) countNext = countNext + CNT_W'(WR_RATIO);
    if (strb.rdAccept) countNext = countNext - CNT_W'(RD_RATIO);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitCount <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      unitCount <= countNext;
      if (strb.wrAccept) wrPtr <= wrPtrNext;
      if (strb.rdAccept) rdPtr <= rdPtrNext;
      overflow  <= wrEn && full;
      underflow <= rdEn && empty;
    end
  end
endmodule

// File: rtl/wc_fifo_data.sv
module wc_fifo_data
  import wc_fifo_pkg::*;
#(
  parameter int UNITS    = 16,
  parameter int NW       = 4,
  parameter int WR_RATIO = 1,
  parameter int RD_RATIO = 2,
  parameter int PTR_W    = $clog2(UNITS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fifoStrobe_t              strb,
  input  logic [PTR_W-1:0]         wrPtr,
  input  logic [PTR_W-1:0]         rdPtr,
  input  logic [WR_RATIO*NW-1:0]   wrData,
  output logic [RD_RATIO*NW-1:0]   rdData,
  output logic                     rdValid
);
  logic [NW-1:0] unitMem [UNITS];
  logic [RD_RATIO*NW-1:0] rdGather;

  // Lane i of a write goes to unit wrPtr+i: least significant first
  always_ff @(posedge clk) begin
    if (strb.wrAccept) begin
      for (int i = 0; i < WR_RATIO; i++) begin
        unitMem[wrPtr + PTR_W'(i)] <= wrData[i*NW +: NW];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < RD_RATIO; i++) begin
      rdGather[i*NW +: NW] = unitMem[rdPtr + PTR_W'(i)];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdAccept;
      if (strb.rdAccept) rdData <= rdGather;
    end
  end
endmodule

// File: rtl/wc_fifo.sv
module wc_fifo
  import wc_fifo_pkg::*;
#(
  parameter int WR_W  = 4,
  parameter int RD_W  = 8,
  parameter int UNITS = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [WR_W-1:0] wrData,
  input  logic            rdEn,
  output logic [RD_W-1:0] rdData,
  output logic            rdValid,
  output logic            full,
  output logic            empty,
  output logic            overflow,
  output logic            underflow
);
  localparam int NW       = (WR_W < RD_W) ? WR_W : RD_W;
  localparam int WR_RATIO = WR_W / NW;
  localparam int RD_RATIO = RD_W / NW;
  localparam int PTR_W    = $clog2(UNITS);
  localparam int CNT_W    = $clog2(UNITS + 1);

  fifoStrobe_t      strb;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  wc_fifo_ctrl #(
    .UNITS(UNITS), .WR_RATIO(WR_RATIO), .RD_RATIO(RD_RATIO),
    .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .strb(strb),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .full(full), .empty(empty),
    .overflow(overflow), .underflow(underflow)
  );

  wc_fifo_data #(
    .UNITS(UNITS), .NW(NW), .WR_RATIO(WR_RATIO), .RD_RATIO(RD_RATIO),
    .PTR_W(PTR_W)
  ) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/wc_fifo_chk.sv
module wc_fifo_chk #(
  parameter int WR_W = 4,
  parameter int RD_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrEn,
  input logic            rdEn,
  input logic [RD_W-1:0] rdData,
  input logic            rdValid,
  input logic            full,
  input logic            empty,
  input logic            overflow,
  input logic            underflow
);
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN) full && !rdEn |=> full); // R4
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rstN) empty && !wrEn |=> empty); // R5
  AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN) wrEn && full |=> overflow); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN) !(wrEn && full) |=> !overflow); // R6
  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN) rdEn && empty |=> underflow && !rdValid); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN) !(rdEn && empty) |=> !underflow); // R7
  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rstN) rdEn && !empty |=> rdValid); // R8
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN) !rdValid |-> $stable(rdData)); // R8
endmodule

bind wc_fifo wc_fifo_chk #(.WR_W(WR_W), .RD_W(RD_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData),
  .rdValid(rdValid), .full(full), .empty(empty),
  .overflow(overflow), .underflow(underflow)
);

// File: tb/wc_fifo_tb_top.sv
module wc_fifo_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  // Narrow-write instance: 4-bit in, 8-bit out, 16 units
  logic       wrEn = 0, rdEn = 0;
  logic [3:0] wrData = '0;
  logic [7:0] rdData;
  logic       rdValid, full, empty, overflow, underflow;

  wc_fifo #(.WR_W(4), .RD_W(8), .UNITS(16)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .rdValid(rdValid), .full(full), .empty(empty),
    .overflow(overflow), .underflow(underflow)
  );

  // Wide-write instance: 16-bit in, 8-bit out, 8 units
  logic        wWrEn = 0, wRdEn = 0;
  logic [15:0] wWrData = '0;
  logic [7:0]  wRdData;
  logic        wRdValid, wFull, wEmpty, wOverflow, wUnderflow;

  wc_fifo #(.WR_W(16), .RD_W(8), .UNITS(8)) dutWide_i (
    .clk(clk), .rstN(rstN), .wrEn(wWrEn), .wrData(wWrData), .rdEn(wRdEn),
    .rdData(wRdData), .rdValid(wRdValid), .full(wFull), .empty(wEmpty),
    .overflow(wOverflow), .underflow(wUnderflow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic tReset();
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 rdValid", rdValid, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 underflow", underflow, 0);
    chk("R1 wide empty", wEmpty, 1);
  endtask

  task automatic tPack();
    wrEn = 1; wrData = 4'hA; tick(); wrEn = 0;
    chk("R5 partial word keeps empty", empty, 1);
    rdEn = 1; tick(); rdEn = 0;
    chk("R7 underflow pulse", underflow, 1);
    chk("R7 no valid on empty read", rdValid, 0);
    tick();
    chk("R7 underflow one cycle", underflow, 0);
    wrEn = 1; wrData = 4'h5; tick(); wrEn = 0;
    chk("R5 empty clears at whole word", empty, 0);
    rdEn = 1; tick(); rdEn = 0;
    chk("R8 rdValid pulse", rdValid, 1);
    chk("R2 packed LSB first", rdData, 8'h5A);
    tick();
    chk("R8 rdValid one cycle", rdValid, 0);
    chk("R8 rdData held", rdData, 8'h5A);
    chk("R5 empty after drain", empty, 1);
  endtask

  task automatic tFull();
    for (int i = 0; i < 16; i++) begin
      chk("R4 not full while room", full, 0);
      wrEn = 1; wrData = 4'(i); tick();
    end
    wrEn = 0;
    chk("R4 full at capacity", full, 1);
    wrEn = 1; wrData = 4'hF; tick(); wrEn = 0;
    chk("R6 overflow pulse", overflow, 1);
    chk("R6 still full", full, 1);
    tick();
    chk("R6 overflow one cycle", overflow, 0);
    for (int k = 0; k < 8; k++) begin
      rdEn = 1; tick(); rdEn = 0;
      chk("R6 data intact after dropped write", rdData, {4'(2*k+1), 4'(2*k)});
      chk("R4 full clears after read", full, 0);
    end
    chk("R5 empty after full drain", empty, 1);
    rdEn = 1; tick(); rdEn = 0;
    chk("R7 no extra data stored", underflow, 1);
    tick();
  endtask

  task automatic tWide();
    wWrEn = 1; wWrData = 16'hABCD; tick(); wWrEn = 0;
    chk("R3 wide not empty", wEmpty, 0);
    wRdEn = 1; tick();
    chk("R3 low byte first", wRdData, 8'hCD);
    tick(); wRdEn = 0;
    chk("R3 high byte second", wRdData, 8'hAB);
    chk("R5 wide empty", wEmpty, 1);
    for (int i = 0; i < 4; i++) begin
      wWrEn = 1; wWrData = 16'(16'h1111 * (i + 1)); tick();
    end
    wWrEn = 0;
    chk("R4 wide full", wFull, 1);
    wRdEn = 1; tick(); wRdEn = 0;
    chk("R4 half word freed stays full", wFull, 1);
    wRdEn = 1; tick(); wRdEn = 0;
    chk("R4 whole word freed clears full", wFull, 0);
    chk("R3 second unload", wRdData, 8'h11);
  endtask

  task automatic tStream();
    wrEn = 1; wrData = 4'h0; tick();
    wrData = 4'h1; tick();
    for (int k = 0; k < 20; k++) begin
      wrEn = 1; wrData = 4'(k + 2);
      rdEn = (k % 2 == 0);
      tick();
      if (k % 2 == 0) begin
        chk("R9 read with write valid", rdValid, 1);
        chk("R9 order across wrap", rdData, {4'(k + 1), 4'(k)});
      end else begin
        chk("R9 no read no valid", rdValid, 0);
      end
    end
    wrEn = 0; rdEn = 1; tick(); rdEn = 0;
    chk("R9 final byte", rdData, 8'h54);
    chk("R9 empty at end", empty, 1);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12;
    tReset();
    rstN = 1;
    tick();
    tPack();
    tFull();
    tWide();
    tStream();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule